// File: doc/BRIEF.md
# Run-Qualified Sign Edge Detector

This block watches the hard-limited sign of a frequency-discriminator output, sampled 14 times per symbol and qualified by a sample-enable. It marks a symbol boundary only when the sign history shows a sustained run of one polarity directly followed by a sustained run of the opposite polarity. At low SNR a single sign flip is often a noise artefact, so an isolated flip, or a run that is too short, is not reported. Later timing-recovery stages average or complete these marks. This block only produces them.

A 20-sample window slides by one position on every enabled sample. The newest sample enters at bit 0. When the window holds ten equal samples followed by ten samples of the opposite value, the block raises a one-clock timing pulse. That pulse lags the true sign change by ten samples, and downstream logic compensates for this fixed delay. Until 20 samples have entered after reset, the window still holds reset zeros and cannot be trusted. The block suppresses pulses during that time and signals readiness on a separate flag.

Top module: `runedge_detector`

## Requirements
- R1: Synchronous active-high reset clears the window and the fill count. While reset is high, and in the first clock after it, `edge_pulse` and `win_valid` are 0.
- R2: The window advances only on clocks where `smp_en` is 1. `smp_sign` values presented while `smp_en` is 0 have no effect on later pulses.
- R3: Falling change: when the window reads 1111111111_0000000000 (bit 19 down to bit 0, bit 0 newest), `edge_pulse` is 1 in the clock after the enable edge that shifted in the tenth 0.
- R4: Rising change: when the window reads 0000000000_1111111111, `edge_pulse` is 1 in the clock after the enable edge that shifted in the tenth 1.
- R5: `edge_pulse` is high for exactly one clock period. It is 0 in every clock that does not directly follow an enabled sample.
- R6: Any other window content gives no pulse. This covers runs of nine, and a run of ten broken by one opposite sample.
- R7: No pulse is issued before 20 samples have been shifted in since reset, even if the partly filled window matches a pattern.
- R8: `win_valid` goes to 1 in the clock after the 20th enabled sample since reset. It stays 1 until the next reset.
- R9: Long runs give exactly one pulse per polarity change. An alternating pattern of 10-sample runs gives one pulse every 10 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Qualifies `smp_sign` as a new sample |
| smp_sign | input | 1 | Hard-limited discriminator sign (1 = positive) |
| edge_pulse | output | 1 | One-clock pulse on a qualified polarity change |
| win_valid | output | 1 | Window holds 20 post-reset samples |

## Verification
Both outputs are registered at the same enable edge that shifts the sample in. So `edge_pulse` and `win_valid` are due in the clock directly after the edge that carries the qualifying sample, that is the tenth sample of the new polarity, or the 20th sample since reset. The bench drives each sample at a falling clock edge and reads the outputs 1 ns after the next rising edge. It records the index of the sample at which a pulse appeared and compares that index with the expected one. The bench also inserts idle clocks with toggling sign between samples. In those clocks it checks that no pulse appears there and that the idle values do not move the expected pulse.

// File: rtl/runedge_pkg.sv
package runedge_pkg;

    // Default window length in samples; both runs are half of it.
    localparam int WIN_LEN_DEF = 20;

    // Classification of the window contents.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2
    } edge_kind_e;

    // Window state handed from the shift stage to the pulse stage.
    typedef struct packed {
        logic full_next;  // window will hold WIN_LEN samples after this edge
        logic shifting;   // this clock carries a new sample
    } win_ctl_t;

    function automatic logic is_edge(input edge_kind_e k);
        return (k != EDGE_NONE);
    endfunction

endpackage

// File: rtl/runedge_window.sv
module runedge_window
    import runedge_pkg::*;
#(
    parameter int WIN_LEN = WIN_LEN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_en,
    input  logic               smp_sign,
    output logic [WIN_LEN-1:0] win_q,
    output logic [WIN_LEN-1:0] win_next,
    output win_ctl_t           ctl
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WIN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    // Newest sample enters at bit 0.
    always_comb begin
        win_next = win_q;
        cnt_next = cnt_q;
        if (smp_en) begin
            win_next = {win_q[WIN_LEN-2:0], smp_sign};
            if (cnt_q != FULL_CNT) begin
                cnt_next = cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.full_next = (cnt_next == FULL_CNT);
        ctl.shifting  = smp_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_next;
            cnt_q <= cnt_next;
        end
    end

    // R2: window frozen on clocks without a sample
    a_r2_window_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(win_q));

    // R7: fill count saturates at the window length
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/runedge_matcher.sv
module runedge_matcher
    import runedge_pkg::*;
#(
    parameter int WIN_LEN = WIN_LEN_DEF
) (
    input  logic [WIN_LEN-1:0] win,
    output edge_kind_e         kind
);
    localparam int RUN = WIN_LEN / 2;
    localparam logic [WIN_LEN-1:0] FALL_PAT = {{RUN{1'b1}}, {RUN{1'b0}}};
    localparam logic [WIN_LEN-1:0] RISE_PAT = {{RUN{1'b0}}, {RUN{1'b1}}};

    always_comb begin
        if (win == FALL_PAT) begin
            kind = EDGE_FALL;
        end else if (win == RISE_PAT) begin
            kind = EDGE_RISE;
        end else begin
            kind = EDGE_NONE;
        end
    end

endmodule

// File: rtl/runedge_pulse.sv
module runedge_pulse
    import runedge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  win_ctl_t   ctl,
    input  edge_kind_e kind,
    output logic       pulse_q,
    output logic       valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= ctl.full_next;
            pulse_q <= ctl.shifting && ctl.full_next && is_edge(kind);
        end
    end

    // R5: a pulse never lasts two clocks
    a_r5_single_clock: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R5: a pulse only follows a clock that carried a sample
    a_r5_after_sample: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(ctl.shifting));

    // R7: no pulse while the window is not yet filled
    a_r7_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> valid_q);

    // R8: readiness is sticky until reset
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q);

endmodule

// File: rtl/runedge_detector.sv
module runedge_detector
    import runedge_pkg::*;
#(
    parameter int WIN_LEN = WIN_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic smp_sign,
    output logic edge_pulse,
    output logic win_valid
);
    localparam int RUN = WIN_LEN / 2;
    localparam logic [WIN_LEN-1:0] CHK_FALL = {{RUN{1'b1}}, {RUN{1'b0}}};
    localparam logic [WIN_LEN-1:0] CHK_RISE = {{RUN{1'b0}}, {RUN{1'b1}}};

    logic [WIN_LEN-1:0] win_q;
    logic [WIN_LEN-1:0] win_next;
    win_ctl_t           ctl;
    edge_kind_e         kind;

    runedge_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk      (clk),
        .rst      (rst),
        .smp_en   (smp_en),
        .smp_sign (smp_sign),
        .win_q    (win_q),
        .win_next (win_next),
        .ctl      (ctl)
    );

    // Classify the window as it will stand after this edge.
    runedge_matcher #(.WIN_LEN(WIN_LEN)) u_match (
        .win  (win_next),
        .kind (kind)
    );

    runedge_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .kind    (kind),
        .pulse_q (edge_pulse),
        .valid_q (win_valid)
    );

    // R3/R4/R6: a pulse is seen only while the stored window holds a pattern
    a_r6_pattern_only: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |-> (win_q == CHK_FALL || win_q == CHK_RISE));

    // R1: outputs are clear in the clock after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!edge_pulse && !win_valid));

endmodule

// File: tb/sim_runedge_detector.sv
module sim_runedge_detector;
    logic clk = 1'b0;
    logic rst;
    logic smp_en;
    logic smp_sign;
    logic edge_pulse;
    logic win_valid;

    int checks = 0;
    int failures = 0;
    int pcount;
    int plast;
    int gap_pulses;
    bit done = 0;

    always #2 clk = ~clk;

    runedge_detector u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_en     (smp_en),
        .smp_sign   (smp_sign),
        .edge_pulse (edge_pulse),
        .win_valid  (win_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_en = 1'b0; smp_sign = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(edge_pulse == 1'b0, "R1 pulse in reset", int'(edge_pulse), 0);
        chk(win_valid == 1'b0, "R1 valid in reset", int'(win_valid), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Feed n samples of value b; gap idle clocks after each, with inverted sign.
    task automatic feed(input bit b, input int n, input int gap);
        pcount = 0; plast = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            smp_en = 1'b1; smp_sign = b;
            @(posedge clk);
            #1;
            if (edge_pulse) begin pcount++; plast = i; end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                smp_en = 1'b0; smp_sign = ~b;
                @(posedge clk);
                #1;
                if (edge_pulse) gap_pulses++;
            end
        end
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic t_fill();
        do_reset();
        @(posedge clk); #1;
        chk(edge_pulse == 1'b0 && win_valid == 1'b0, "R1 after release", int'(win_valid), 0);
        feed(1'b1, 10, 0);
        chk(pcount == 0, "R7 early rise pattern suppressed", pcount, 0);
        feed(1'b0, 9, 0);
        chk(win_valid == 1'b0, "R8 valid after 19 samples", int'(win_valid), 0);
        feed(1'b0, 1, 0);
        chk(pcount == 1, "R7 first pulse at 20th sample", pcount, 1);
        chk(win_valid == 1'b1, "R8 valid after 20 samples", int'(win_valid), 1);
    endtask

    task automatic t_fall_rise();
        do_reset();
        feed(1'b1, 20, 0);
        chk(pcount == 0, "R6 all ones no pulse", pcount, 0);
        feed(1'b0, 10, 0);
        chk(pcount == 1 && plast == 10, "R3 falling pulse at tenth zero", plast, 10);
        feed(1'b1, 10, 0);
        chk(pcount == 1 && plast == 10, "R4 rising pulse at tenth one", plast, 10);
    endtask

    task automatic t_width();
        do_reset();
        gap_pulses = 0;
        feed(1'b0, 25, 2);
        feed(1'b1, 12, 2);
        chk(pcount == 1 && plast == 10, "R2 idle junk ignored, rise at tenth", plast, 10);
        chk(gap_pulses == 0, "R5 no pulse in idle clocks", gap_pulses, 0);
        feed(1'b0, 12, 1);
        chk(pcount == 1 && plast == 10, "R2 fall with gaps", plast, 10);
        chk(gap_pulses == 0, "R5 pulse one clock wide", gap_pulses, 0);
        // Long idle with sign toggling must not shift anything in.
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); smp_en = 1'b0; smp_sign = k[0];
            @(posedge clk); #1;
            if (edge_pulse) gap_pulses++;
        end
        chk(gap_pulses == 0, "R2 idle toggling has no effect", gap_pulses, 0);
        feed(1'b1, 10, 0);
        chk(pcount == 1 && plast == 10, "R2 window intact after idle", plast, 10);
    endtask

    task automatic t_reject();
        do_reset();
        feed(1'b1, 25, 0);
        feed(1'b0, 9, 0);
        feed(1'b1, 1, 0);
        feed(1'b0, 10, 0);
        chk(pcount == 0, "R6 broken run no pulse", pcount, 0);
        do_reset();
        feed(1'b1, 25, 0);
        feed(1'b0, 9, 0);
        chk(pcount == 0, "R6 nine zeros no pulse", pcount, 0);
        feed(1'b1, 15, 0);
        chk(pcount == 0, "R6 nine-run then ones no pulse", pcount, 0);
        pcount = 0;
        for (int k = 0; k < 30; k++) begin
            feed(k[0], 1, 0);
            chk(pcount == 0, "R6 alternating no pulse", pcount, 0);
        end
    endtask

    task automatic t_long();
        int tot;
        do_reset();
        feed(1'b1, 25, 0);
        feed(1'b0, 30, 0);
        chk(pcount == 1 && plast == 10, "R9 long fall single pulse", pcount, 1);
        feed(1'b1, 30, 0);
        chk(pcount == 1 && plast == 10, "R9 long rise single pulse", pcount, 1);
        tot = 0;
        for (int k = 0; k < 4; k++) begin
            feed(k[0] ? 1'b1 : 1'b0, 10, 0);
            if (pcount == 1 && plast == 10) tot++;
        end
        chk(tot == 4, "R9 square wave pulse every 10 samples", tot, 4);
    endtask

    task automatic t_mid_reset();
        do_reset();
        feed(1'b1, 22, 0);
        chk(win_valid == 1'b1, "R8 valid before reset", int'(win_valid), 1);
        do_reset();
        @(posedge clk); #1;
        chk(win_valid == 1'b0, "R1 valid cleared by reset", int'(win_valid), 0);
        feed(1'b0, 10, 0);
        chk(pcount == 0, "R7 no pulse after reset refill", pcount, 0);
    endtask

    initial begin
        rst = 1'b1; smp_en = 1'b0; smp_sign = 1'b0;
        t_fill();
        t_fall_rise();
        t_width();
        t_reject();
        t_long();
        t_mid_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule